// File: doc/BRIEF.md
# Beacon Coarse-Sync Preamble Generator

This block drives the pulse-by-pulse content of the coarse-synchronization preamble that opens a beacon. A preamble run is a base pattern of 79 pulses, transmitted 123 times over. Each pulse carries two values. The first is a time-hopping offset, counted in 50 ps steps inside a 5.4 ns pulse period. The second is a polarity bit taken from one row of a Paley-type Hadamard matrix of order 80. Twenty piconet codes are available, and each gives a different hop pattern and a different polarity row. The last repetitions form a closing signature: the sign applied to a whole repetition runs +, +, +, −, − over the final five repetitions. A receiver uses this to find where the preamble ends.

The transmitter loads a piconet number and gives a start strobe. After that it sends one tick per pulse period. The generator answers each tick with a one-cycle pulse strobe, which carries the offset, the polarity and the signature flag. After the final pulse it raises a one-cycle completion flag.

Top module: `beacon_preamble_gen`

## Requirements
- R1: While reset is applied, and afterwards until a run is started, pulse_o, hop_o, pol_o, eobp_o and done_o are all zero.
- R2: A start strobe begins a run only if seq_sel_i holds a code from 1 to 20 and no run is active. A start carrying 0 or any value from 21 to 31 does nothing, and no pulses follow it.
- R3: During a run, every tick_i sampled at a clock edge gives pulse_o high for exactly the cycle after that edge. pulse_o is never high at any other time. A tick sampled at the same edge that accepts a start gives no pulse.
- R4: One run produces 9717 pulses. The pulse index n steps 0..78 inside a repetition, and there are 123 repetitions (numbered 0..122).
- R5: For each pulse, hop_o equals (i·n²) mod 79, where i is the code latched at start. The value is always in 0..78.
- R6: Outside the inverted repetitions, pol_o follows a fixed rule, where 1 means positive. Pulse n=0 is 0. Pulse n=i is 1. Any other pulse is 1 exactly when (i−n) mod 79 is a nonzero square modulo 79.
- R7: In repetitions 121 and 122, every polarity bit is the inverse of the R6 value. The whole-repetition sign over repetitions 118..122 is therefore + + + − −.
- R8: eobp_o is high together with every pulse of repetitions 120..122, and low for every earlier pulse.
- R9: done_o is high for exactly one cycle, the cycle after the final pulse. The run ends at the edge that samples its final tick, so a start can be accepted in the cycle that shows the final pulse.
- R10: A start strobe sampled while a run is active has no effect. The latched code and the position in the pulse order continue unchanged.
- R11: When pulse_o is low, hop_o, pol_o and eobp_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a preamble run |
| seq_sel_i | input | 5 | Piconet code, 1..20 |
| tick_i | input | 1 | Pulse-period tick |
| pulse_o | output | 1 | One-cycle pulse strobe |
| hop_o | output | 7 | Hop offset in 50 ps steps |
| pol_o | output | 1 | Pulse polarity, 1 = positive |
| eobp_o | output | 1 | Pulse belongs to the end-of-preamble signature |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The sensitive overlap is where one run ends and the next begins. The final pulse of a run and the start of the next run can fall in the same cycle, and the new run is then already active while done_o of the old run is still to appear. The bench provokes this by driving start in the exact cycle that shows the final pulse, and again in the done cycle. It also places a tick in the start cycle and in the done cycle. A cycle-level reference model, written from the requirements, judges the result: it checks that the old run still gives exactly one done_o after 9717 pulses, and that the new run starts from n=0 in repetition 0 with the newly latched code.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Block configuration
  localparam int SEQ_LEN     = 79;   // pulses per base pattern (prime)
  localparam int NUM_SEQ     = 20;   // selectable piconet codes
  localparam int NORMAL_REPS = 120;  // plain repetitions
  localparam int SIG_REPS    = 3;    // signature repetitions at the end
  localparam int FLIP_REPS   = 2;    // trailing repetitions sent inverted

  // Hop index arithmetic: (i * n^2) mod q
  function automatic int hop_index(input int i, input int n, input int q);
    return (i * n * n) % q;
  endfunction

endpackage

// File: rtl/bp_step_counter.sv
module bp_step_counter #(
  parameter int SEQ_LEN    = 79,
  parameter int TOTAL_REPS = 123,
  parameter int NUM_SEQ    = 20,
  parameter int IDX_W      = 7,
  parameter int REP_W      = 7,
  parameter int SEL_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] seq_sel_i,
  input  logic             tick_i,
  output logic             fire_o,
  output logic             last_o,
  output logic [SEL_W-1:0] seq_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [REP_W-1:0] rep_o
);

  logic             busy_q;
  logic [SEL_W-1:0] seq_q;
  logic [IDX_W-1:0] idx_q;
  logic [REP_W-1:0] rep_q;

  logic sel_valid, accept, idx_end, rep_end;

  assign sel_valid = (seq_sel_i != '0) && (seq_sel_i <= SEL_W'(NUM_SEQ));
  assign accept    = start_i && !busy_q && sel_valid;
  assign fire_o    = tick_i && busy_q;
  assign idx_end   = (idx_q == IDX_W'(SEQ_LEN - 1));
  assign rep_end   = (rep_q == REP_W'(TOTAL_REPS - 1));
  assign last_o    = fire_o && idx_end && rep_end;

  assign seq_o = seq_q;
  assign idx_o = idx_q;
  assign rep_o = rep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      seq_q  <= '0;
      idx_q  <= '0;
      rep_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      seq_q  <= seq_sel_i;
      idx_q  <= '0;
      rep_q  <= '0;
    end else if (fire_o) begin
      if (idx_end) begin
        idx_q <= '0;
        if (rep_end) busy_q <= 1'b0;
        else         rep_q  <= rep_q + 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(SEQ_LEN)); // R4

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !tick_i) |=> ($stable(seq_q) && $stable(idx_q) && $stable(rep_q) && busy_q)); // R10

  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !busy_q); // R9

endmodule

// File: rtl/bp_hop_unit.sv
module bp_hop_unit #(
  parameter int SEQ_LEN = 79,
  parameter int IDX_W   = 7,
  parameter int SEL_W   = 5
) (
  input  logic [SEL_W-1:0] seq_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] hop_o
);

  always_comb begin
    hop_o = IDX_W'(bp_pkg::hop_index(int'(seq_i), int'(idx_i), SEQ_LEN));
  end

endmodule

// File: rtl/bp_polarity_unit.sv
module bp_polarity_unit #(
  parameter int SEQ_LEN    = 79,
  parameter int NUM_SEQ    = 20,
  parameter int TOTAL_REPS = 123,
  parameter int SIG_REPS   = 3,
  parameter int FLIP_REPS  = 2,
  parameter int IDX_W      = 7,
  parameter int REP_W      = 7,
  parameter int SEL_W      = 5
) (
  input  logic [SEL_W-1:0] seq_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [REP_W-1:0] rep_i,
  output logic             pol_o,
  output logic             sig_o
);

  typedef logic [SEQ_LEN-1:0]              qr_t;
  typedef logic [NUM_SEQ-1:0][SEQ_LEN-1:0] rows_t;

  // Nonzero squares modulo SEQ_LEN
  function automatic qr_t square_mask();
    qr_t m = '0;
    for (int y = 1; y < SEQ_LEN; y++) m[(y * y) % SEQ_LEN] = 1'b1;
    return m;
  endfunction

  // Paley order-(SEQ_LEN+1) matrix rows 1..NUM_SEQ, columns 0..SEQ_LEN-1
  function automatic rows_t build_rows();
    rows_t r = '0;
    qr_t   m = square_mask();
    for (int k = 0; k < NUM_SEQ; k++) begin
      for (int c = 0; c < SEQ_LEN; c++) begin
        if (c == 0)          r[k][c] = 1'b0;
        else if (c == k + 1) r[k][c] = 1'b1;
        else                 r[k][c] = m[(k + 1 - c + SEQ_LEN) % SEQ_LEN];
      end
    end
    return r;
  endfunction

  localparam rows_t ROWS = build_rows();

  logic [SEL_W-1:0] row_sel;
  logic             flip;

  always_comb begin
    row_sel = (seq_i == '0) ? '0 : seq_i - 1'b1;
    flip    = (rep_i >= REP_W'(TOTAL_REPS - FLIP_REPS));
    sig_o   = (rep_i >= REP_W'(TOTAL_REPS - SIG_REPS));
    pol_o   = ROWS[row_sel][idx_i] ^ flip;
  end

endmodule

// File: rtl/beacon_preamble_gen.sv
module beacon_preamble_gen #(
  parameter int SEQ_LEN     = bp_pkg::SEQ_LEN,
  parameter int NUM_SEQ     = bp_pkg::NUM_SEQ,
  parameter int NORMAL_REPS = bp_pkg::NORMAL_REPS,
  parameter int SIG_REPS    = bp_pkg::SIG_REPS,
  parameter int FLIP_REPS   = bp_pkg::FLIP_REPS,
  localparam int TOTAL_REPS = NORMAL_REPS + SIG_REPS,
  localparam int IDX_W      = $clog2(SEQ_LEN),
  localparam int REP_W      = $clog2(TOTAL_REPS),
  localparam int SEL_W      = $clog2(NUM_SEQ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] seq_sel_i,
  input  logic             tick_i,
  output logic             pulse_o,
  output logic [IDX_W-1:0] hop_o,
  output logic             pol_o,
  output logic             eobp_o,
  output logic             done_o
);

  // Internal events, named for the assertions
  logic             fire, last;
  logic [SEL_W-1:0] cur_seq;
  logic [IDX_W-1:0] cur_idx;
  logic [REP_W-1:0] cur_rep;
  logic [IDX_W-1:0] hop_next;
  logic             pol_next, sig_next;
  logic             last_q, sig_seen_q;

  bp_step_counter #(
    .SEQ_LEN(SEQ_LEN), .TOTAL_REPS(TOTAL_REPS), .NUM_SEQ(NUM_SEQ),
    .IDX_W(IDX_W), .REP_W(REP_W), .SEL_W(SEL_W)
  ) i_counter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .seq_sel_i(seq_sel_i),
    .tick_i(tick_i), .fire_o(fire), .last_o(last),
    .seq_o(cur_seq), .idx_o(cur_idx), .rep_o(cur_rep)
  );

  bp_hop_unit #(
    .SEQ_LEN(SEQ_LEN), .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) i_hop (
    .seq_i(cur_seq), .idx_i(cur_idx), .hop_o(hop_next)
  );

  bp_polarity_unit #(
    .SEQ_LEN(SEQ_LEN), .NUM_SEQ(NUM_SEQ), .TOTAL_REPS(TOTAL_REPS),
    .SIG_REPS(SIG_REPS), .FLIP_REPS(FLIP_REPS),
    .IDX_W(IDX_W), .REP_W(REP_W), .SEL_W(SEL_W)
  ) i_pol (
    .seq_i(cur_seq), .idx_i(cur_idx), .rep_i(cur_rep),
    .pol_o(pol_next), .sig_o(sig_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_o    <= 1'b0;
      hop_o      <= '0;
      pol_o      <= 1'b0;
      eobp_o     <= 1'b0;
      last_q     <= 1'b0;
      done_o     <= 1'b0;
      sig_seen_q <= 1'b0;
    end else begin
      pulse_o <= fire;
      hop_o   <= fire ? hop_next : '0;
      pol_o   <= fire && pol_next;
      eobp_o  <= fire && sig_next;
      last_q  <= last;
      done_o  <= last_q;
      if (done_o)                 sig_seen_q <= 1'b0;
      else if (pulse_o && eobp_o) sig_seen_q <= 1'b1;
    end
  end

  AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(pulse_o)); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_o |-> (hop_o == '0 && !pol_o && !eobp_o)); // R11

  AST_HOP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (hop_o < IDX_W'(SEQ_LEN))); // R5

  AST_SIGNATURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && sig_seen_q) |-> eobp_o); // R8

endmodule

// File: tb/test_beacon_preamble_gen.sv
module test_beacon_preamble_gen;

  localparam int RUN_PULSES = 79 * 123;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [4:0] seq_sel_i = '0;
  logic       tick_i = 1'b0;
  logic       pulse_o, pol_o, eobp_o, done_o;
  logic [6:0] hop_o;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // reference model state
  bit m_busy = 0;
  bit m_fin  = 0;
  int m_seq = 0, m_n = 0, m_rep = 0;
  bit e_pulse = 0, e_pol = 0, e_eobp = 0, e_done = 0;
  int e_hop = 0;
  int obs_pulses = 0;
  int done_seen = 0;
  string note = "";

  always #5 clk = ~clk;

  beacon_preamble_gen i_beacon_preamble_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .seq_sel_i(seq_sel_i),
    .tick_i(tick_i), .pulse_o(pulse_o), .hop_o(hop_o), .pol_o(pol_o),
    .eobp_o(eobp_o), .done_o(done_o)
  );

  // i*n^2 mod 79 by summing odd multiples
  function automatic int ref_hop(input int i, input int n);
    int acc = 0;
    for (int k = 0; k < n; k++) acc = (acc + i * (2 * k + 1)) % 79;
    return acc;
  endfunction

  // Euler criterion: x^39 mod 79 == 1
  function automatic bit is_square(input int x);
    int p = 1;
    for (int k = 0; k < 39; k++) p = (p * x) % 79;
    return (p == 1);
  endfunction

  function automatic bit ref_pol(input int i, input int n);
    if (n == 0) return 1'b0;
    if (n == i) return 1'b1;
    return is_square((i - n + 79) % 79);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s%s actual=%0d expected=%0d", tag, what, note, act, exp);
    end
  endtask

  task automatic check_outputs();
    check("R3", "pulse_o", int'(pulse_o), int'(e_pulse));
    check("R9", "done_o", int'(done_o), int'(e_done));
    if (e_pulse) begin
      check("R5", "hop_o", int'(hop_o), e_hop);
      check((m_rep >= 121 || (e_eobp && !m_busy)) ? "R7" : "R6", "pol_o", int'(pol_o), int'(e_pol));
      check("R8", "eobp_o", int'(eobp_o), int'(e_eobp));
    end else begin
      check("R11", "hop_o idle", int'(hop_o), 0);
      check("R11", "pol_o idle", int'(pol_o), 0);
      check("R11", "eobp_o idle", int'(eobp_o), 0);
    end
    if (pulse_o) obs_pulses++;
    if (done_o) begin
      done_seen++;
      check("R4", "pulses per run", obs_pulses, RUN_PULSES);
      obs_pulses = 0;
    end
  endtask

  // one cycle: check previous result, apply stimulus, advance model
  task automatic step(input bit st, input int sel, input bit tk);
    check_outputs();
    start_i   = st;
    seq_sel_i = 5'(sel);
    tick_i    = tk;
    e_done = m_fin;
    m_fin  = 0;
    if (m_busy && tk) begin
      e_pulse = 1;
      e_hop   = ref_hop(m_seq, m_n);
      e_pol   = ref_pol(m_seq, m_n) ^ (m_rep >= 121);
      e_eobp  = (m_rep >= 120);
      if (m_n == 78) begin
        m_n = 0;
        if (m_rep == 122) begin m_fin = 1; m_busy = 0; end
        else m_rep++;
      end else m_n++;
    end else begin
      e_pulse = 0; e_hop = 0; e_pol = 0; e_eobp = 0;
      if (st && !m_busy && sel >= 1 && sel <= 20) begin
        m_busy = 1; m_seq = sel; m_n = 0; m_rep = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic random_run(input bit with_starts);
    while (m_busy) begin
      bit st = with_starts && (($urandom % 97) == 0);
      note = st ? " (R10 start during run)" : "";
      step(st, int'($urandom % 32), ($urandom % 3) != 0);
    end
    note = "";
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      finished = 1'b1;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=200000", cycles);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7919));
    repeat (4) @(negedge clk);
    check("R1", "pulse_o in reset", int'(pulse_o), 0);
    check("R1", "done_o in reset", int'(done_o), 0);
    check("R1", "hop_o in reset", int'(hop_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "eobp_o after reset", int'(eobp_o), 0);
    check("R1", "pol_o after reset", int'(pol_o), 0);

    // R2: invalid codes ignored
    step(1, 0, 1);  step(0, 0, 1); step(0, 0, 1);
    step(1, 21, 0); step(0, 0, 1); step(0, 0, 1);
    step(1, 31, 1); step(0, 0, 1); step(0, 0, 1);
    step(0, 0, 0);
    check("R2", "pulses after invalid starts", obs_pulses, 0);

    // run A, code 1, tick in start cycle (R3), random ignored starts (R10)
    step(1, 1, 1);
    random_run(1'b1);
    // restart in the cycle showing the final pulse, code 20 (R9)
    note = " (R9 restart at final pulse)";
    step(1, 20, 0);
    step(0, 0, 1);   // tick in the done cycle
    note = "";
    random_run(1'b1);
    // start in the done cycle with a random valid code
    step(0, 0, 1);
    step(1, 1 + int'($urandom % 20), 1);
    random_run(1'b0);
    repeat (4) step(0, 0, 1);
    step(0, 0, 0);
    check("R9", "done pulses over three runs", done_seen, 3);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule